// File: doc/BRIEF.md
# GPIO Event and Interrupt Detector

This block watches a 32-bit word of input data, already corrected for polarity and masked by the pin logic upstream, and records events on each bit in a sticky status register. Each bit can be set to report a high level, a rising edge only, or any change. A single interrupt line is high while any status bit whose enable bit is set is high. Software clears status bits by writing ones to them, and changes enables either with a full write or with separate set and clear aliases. These aliases change only the bits written, so no read-modify-write is needed.

Edges are found by comparing the input word with a copy of itself registered on the previous clock. A level-mode bit whose input stays high is set again on the same edge as a clear. A set condition on a bit wins over a clear of that same bit in the same cycle. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset every readable register (event type, both-edges, enable, status) reads zero and `irq` is low.
- R2: A bit whose event-type bit is 0 (level mode) has its status bit set on the edge after a clock where its input data bit is high.
- R3: A bit with event-type 1 and both-edges 0 sets its status only where the input bit was 0 on the previous clock and is 1 now. A falling edge or an unchanged input sets nothing.
- R4: A bit with event-type 1 and both-edges 1 sets its status on any change of its input bit between two clocks.
- R5: Writing the status register (address 5) clears each status bit whose write-data bit is 1 and leaves the others unchanged. Status bits are never set without a set condition.
- R6: When a set condition and a clear write hit the same status bit in the same cycle, the bit ends up set. So a level-mode bit whose input is still high reads 1 after a clear.
- R7: A write to the enable-set alias (address 3) ORs the data into the enable register (address 2). The alias reads zero.
- R8: A write to the enable-clear alias (address 4) clears the enable bits where the data is 1. The alias reads zero.
- R9: `irq` is high exactly when the AND of status and enable is nonzero.
- R10: Writing event-type (address 0), both-edges (address 1) or enable never creates an edge event. A bit switched to edge mode while its input is steady stays clear once it has been cleared.
- R11: Reads of addresses 6 and 7 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 32 | Input data word after polarity and masking |
| we | input | 1 | Register write strobe |
| waddr | input | 3 | Write address |
| wdata | input | 32 | Write data |
| raddr | input | 3 | Read address |
| rdata | output | 32 | Read data for `raddr` (combinational) |
| irq | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
The assertions assume that `din`, `we`, `waddr` and `wdata` are synchronous to `clk` and stable around its rising edge. They also assume that the checker's copy of the previous input word starts from the same zero as the block's copy. The bench changes every input on the falling edge and holds `din` at zero across reset release. Random writes cover all eight addresses, including the two unused ones and the clear and set aliases. Bits of `din` are kept steady for long stretches so that level re-arm and the no-edge cases actually occur.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_TYPE    = 3'd0,
    REG_BOTH    = 3'd1,
    REG_ENA     = 3'd2,
    REG_ENA_SET = 3'd3,
    REG_ENA_CLR = 3'd4,
    REG_STAT    = 3'd5
  } evt_reg_e;
endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
  import gpio_evt_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      evt_type,
  output logic [N-1:0]      both_edge,
  output logic [N-1:0]      ena
);
  logic [N-1:0] type_d, both_d, ena_d;
  logic         type_en, both_en, ena_en;

  always_comb begin
    type_en = 1'b0;
    both_en = 1'b0;
    ena_en  = 1'b0;
    type_d  = evt_type;
    both_d  = both_edge;
    ena_d   = ena;
    if (we) begin
      unique case (waddr)
        REG_TYPE:    begin type_en = 1'b1; type_d = wdata; end
        REG_BOTH:    begin both_en = 1'b1; both_d = wdata; end
        REG_ENA:     begin ena_en = 1'b1; ena_d = wdata; end
        REG_ENA_SET: begin ena_en = 1'b1; ena_d = ena | wdata; end
        REG_ENA_CLR: begin ena_en = 1'b1; ena_d = ena & ~wdata; end
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_type  <= '0;
      both_edge <= '0;
      ena       <= '0;
    end else begin
      if (type_en) evt_type  <= type_d;
      if (both_en) both_edge <= both_d;
      if (ena_en)  ena       <= ena_d;
    end
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  input  logic [N-1:0] evt_type,
  input  logic [N-1:0] both_edge,
  output logic [N-1:0] set_vec
);
  logic [N-1:0] din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise, fall;
    always_comb begin
      rise = din[i] & ~din_q[i];
      fall = ~din[i] & din_q[i];
      if (!evt_type[i])      set_vec[i] = din[i];
      else if (both_edge[i]) set_vec[i] = rise | fall;
      else                   set_vec[i] = rise;
    end
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] ena,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] status_d;

  always_comb begin
    status_d = (status & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  assign irq = |(status & ena);
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
  import gpio_evt_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      din,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [N-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [N-1:0]      rdata,
  output logic              irq
);
  logic       rst_sync;
  logic [1:0] rst_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  logic [N-1:0] evt_type, both_edge, ena, status, set_vec, clr_vec;

  gpio_evt_cfg #(.N(N)) u_cfg (
    .clk(clk), .rst_n(rst_sync), .we(we), .waddr(waddr), .wdata(wdata),
    .evt_type(evt_type), .both_edge(both_edge), .ena(ena)
  );

  gpio_evt_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_sync), .din(din), .evt_type(evt_type),
    .both_edge(both_edge), .set_vec(set_vec)
  );

  assign clr_vec = (we && waddr == REG_STAT) ? wdata : '0;

  gpio_evt_status #(.N(N)) u_stat (
    .clk(clk), .rst_n(rst_sync), .set_vec(set_vec), .clr_vec(clr_vec),
    .ena(ena), .status(status), .irq(irq)
  );

  always_comb begin
    case (raddr)
      REG_TYPE: rdata = evt_type;
      REG_BOTH: rdata = both_edge;
      REG_ENA:  rdata = ena;
      REG_STAT: rdata = status;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_evt_irq_chk.sv
module gpio_evt_irq_chk
  import gpio_evt_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      din,
  input logic              we,
  input logic [ADDR_W-1:0] waddr,
  input logic [N-1:0]      wdata,
  input logic [N-1:0]      evt_type,
  input logic [N-1:0]      ena,
  input logic [N-1:0]      status,
  input logic [N-1:0]      set_vec,
  input logic              irq
);
  logic [N-1:0] din_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_prev <= '0;
    else        din_prev <= din;
  end

  // R2: a high level-mode input leaves its status bit set
  a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(evt_type) & $past(din) & ~status) == '0));

  // R3 / R10: an edge-mode bit with a steady input gains no new status
  a_r3_no_edge_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(evt_type)
               & ~($past(din) ^ $past(din_prev))) == '0));

  // R5: a status bit rises only where a set condition was present
  a_r5_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

  // R6: a set condition always leaves the bit set, even under a clear write
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~status) == '0));

  // R7: the set alias forces the written enable bits on
  a_r7_ena_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == REG_ENA_SET) |=> ((ena & $past(wdata)) == $past(wdata)));

  // R8: the clear alias forces the written enable bits off
  a_r8_ena_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == REG_ENA_CLR) |=> ((ena & $past(wdata)) == '0));

  // R9: the interrupt needs an enabled status bit
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ena) != '0));
endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_sync), .din(din), .we(we), .waddr(waddr),
  .wdata(wdata), .evt_type(evt_type), .ena(ena), .status(status),
  .set_vec(set_vec), .irq(irq)
);

// File: tb/gpio_evt_irq_test.sv
module gpio_evt_irq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] din;
  logic        we;
  logic [2:0]  waddr;
  logic [31:0] wdata;
  logic [2:0]  raddr;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_type, m_both, m_ena, m_stat, m_prev;

  always #10 clk = ~clk;

  gpio_evt_irq uut (
    .clk(clk), .rst_n(rst_n), .din(din), .we(we), .waddr(waddr),
    .wdata(wdata), .raddr(raddr), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] set_of(input logic [31:0] d, p, t, b);
    return (~t & d) | (t & b & (d ^ p)) | (t & ~b & d & ~p);
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_type;
      3'd1: return m_both;
      3'd2: return m_ena;
      3'd5: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  task automatic expect32(input string tag, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input logic [31:0] d, input logic w,
                      input logic [2:0] a, input logic [31:0] wd);
    logic [31:0] s;
    @(negedge clk);
    din = d; we = w; waddr = a; wdata = wd;
    @(posedge clk);
    s = set_of(d, m_prev, m_type, m_both);
    m_stat = (m_stat & ~((w && a == 3'd5) ? wd : 32'h0)) | s;
    m_prev = d;
    if (w) begin
      case (a)
        3'd0: m_type = wd;
        3'd1: m_both = wd;
        3'd2: m_ena  = wd;
        3'd3: m_ena  = m_ena | wd;
        3'd4: m_ena  = m_ena & ~wd;
        default: ;
      endcase
    end
    #1;
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      raddr = 3'(a);
      #1;
      expect32(tag, rdata, model_read(3'(a)));
    end
    expect32({tag, " irq (R9)"}, {31'h0, irq}, {31'h0, |(m_stat & m_ena)});
  endtask

  task automatic read_at(input logic [2:0] a, output logic [31:0] v);
    raddr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] dr;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; din = '0; we = 1'b0; waddr = '0; wdata = '0; raddr = '0;
    m_type = '0; m_both = '0; m_ena = '0; m_stat = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick(32'h0, 1'b0, 3'd0, 32'h0);
    check_all("R1 reset state");

    // R2: level mode on bit 3
    tick(32'h8, 1'b0, 3'd0, 32'h0);
    read_at(3'd5, v);
    expect32("R2 level sets status", v, 32'h8);

    // R7: enable-set alias and irq
    tick(32'h8, 1'b1, 3'd3, 32'h8);
    read_at(3'd2, v);
    expect32("R7 enable set alias", v, 32'h8);
    read_at(3'd3, v);
    expect32("R7 alias reads zero", v, 32'h0);
    expect32("R9 irq high", {31'h0, irq}, 32'h1);

    // R6: clear while level still high, bit re-arms
    tick(32'h8, 1'b1, 3'd5, 32'h8);
    read_at(3'd5, v);
    expect32("R6 level re-arm beats clear", v, 32'h8);

    // R5: input low, then clear
    tick(32'h0, 1'b0, 3'd0, 32'h0);
    tick(32'h0, 1'b1, 3'd5, 32'h8);
    read_at(3'd5, v);
    expect32("R5 clear status", v, 32'h0);
    expect32("R9 irq low after clear", {31'h0, irq}, 32'h0);

    // R8: enable-clear alias
    tick(32'h0, 1'b1, 3'd2, 32'hF0);
    tick(32'h0, 1'b1, 3'd4, 32'h30);
    read_at(3'd2, v);
    expect32("R8 enable clear alias", v, 32'hC0);
    read_at(3'd4, v);
    expect32("R8 alias reads zero", v, 32'h0);

    // R3: rising only on bit 0
    tick(32'h0, 1'b1, 3'd0, 32'h1);
    tick(32'h1, 1'b0, 3'd0, 32'h0);
    read_at(3'd5, v);
    expect32("R3 rising edge sets", v, 32'h1);
    tick(32'h1, 1'b1, 3'd5, 32'h1);
    tick(32'h0, 1'b0, 3'd0, 32'h0);
    read_at(3'd5, v);
    expect32("R3 falling edge ignored", v, 32'h0);

    // R6: rising edge in the same cycle as clear
    tick(32'h1, 1'b1, 3'd5, 32'h1);
    read_at(3'd5, v);
    expect32("R6 edge beats clear", v, 32'h1);
    tick(32'h1, 1'b1, 3'd5, 32'h1);

    // R4: both edges on bit 0
    tick(32'h1, 1'b1, 3'd1, 32'h1);
    tick(32'h0, 1'b0, 3'd0, 32'h0);
    read_at(3'd5, v);
    expect32("R4 falling edge sets", v, 32'h1);

    // R10: bit 5 high in level mode, switch to edge, clear, stays clear
    tick(32'h20, 1'b1, 3'd5, 32'hFFFF_FFFF);
    tick(32'h20, 1'b1, 3'd0, 32'h21);
    tick(32'h20, 1'b1, 3'd5, 32'h20);
    tick(32'h20, 1'b1, 3'd1, 32'h20);
    tick(32'h20, 1'b1, 3'd2, 32'hFFFF_FFFF);
    read_at(3'd5, v);
    expect32("R10 config writes create no edge", v & 32'h20, 32'h0);

    // R11: unused addresses
    tick(32'h20, 1'b1, 3'd6, 32'hFFFF_FFFF);
    tick(32'h20, 1'b1, 3'd7, 32'hFFFF_FFFF);
    check_all("R11 unused address writes ignored");

    // Random mix, checked each cycle against the model
    dr = $urandom();
    for (int i = 0; i < 400; i++) begin
      logic w;
      if (($urandom() % 4) == 0) dr = dr ^ ($urandom() & $urandom());
      w = (($urandom() % 3) == 0);
      tick(dr, w, 3'($urandom() % 8), $urandom());
      check_all("R2-model random R3 R4 R5 R6 R7 R8");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule